// File: doc/BRIEF.md
# Switchable 3x3 Neighbourhood Pixel Filter

This block sits in a video path and turns a stream of RGB pixels into a filtered stream, one pixel per clock, with a latency of exactly three clocks in every operation. A four-bit operation code chooses one of these operations:

- a point operation: luma-style grey conversion;
- four spatial operations on a 3x3 neighbourhood: smoothing, gradient magnitude, relief and crispening;
- plain pass-through, for every other code.

The input carries a valid qualifier, a frame-start marker on the first pixel of a frame and a line-end marker on the last pixel of every line. The markers leave the block on the same output beat as the pixel they came with.

Two line stores keep the two previous rows, and three column registers slide along the current row. Together they form a window without waiting for future pixels. The window for input pixel (x, y) spans columns x-2..x and rows y-2..y, so its centre is (x-1, y-1). Any coordinate below zero is replaced by zero, which repeats the top row and the left column. The operation code is sampled on each frame-start pixel and holds for the whole frame. This lets software change it at any time without tearing a frame. Lines may be any length up to the line-store depth (960 by default), and idle cycles may appear anywhere in the stream.

Top module: `pix_filter3x3`

## Requirements
- R1: `out_valid` equals `in_valid` from exactly three clocks earlier, including when the input has idle gaps; each output pixel belongs to the input pixel three clocks before it.
- R2: `out_sof` and `out_eol` equal the input markers of the same pixel three clocks earlier, and both stay low whenever `out_valid` is low.
- R3: `cfg_mode` is sampled only when a pixel with `in_sof` high is accepted. The sampled code governs that pixel and every later pixel up to the next frame start, so changes in mid-frame have no effect.
- R4: A code other than 1, 3, 5, 6 or 7 (for example 0, 2, 9 or 15) outputs the input pixel unchanged. The pixel word is packed with red in bits 23:16, green in bits 15:8 and blue in bits 7:0.
- R5: Code 1 outputs (77*R + 150*G + 29*B) >> 8 on all three channels of the current pixel.
- R6: For input pixel (x, y), with x counted from the frame-start pixel or the pixel after a line end, and y counted in lines from the frame start, tap (r, c) of the window (r, c = 0..2) is the pixel at row max(y-2+r, 0) and column max(x-2+c, 0). This holds for frames as narrow as one pixel and as short as one line.
- R7: Code 3 outputs, per channel, the window weighted 1 2 1 / 2 4 2 / 1 2 1 (rows top to bottom), summed and shifted right by 4.
- R8: Code 7 outputs, per channel, 5 times the centre minus the four edge-adjacent taps, clamped to 0..255.
- R9: Code 6 outputs, per channel, the sum with weights -2 -1 0 / -1 1 1 / 0 1 2 plus 128, clamped to 0..255.
- R10: Code 5 outputs, per channel, |Gx| + |Gy|, clamped to 0..255. Gx is the right column weighted 1 2 1 minus the left column weighted 1 2 1. Gy is the bottom row weighted 1 2 1 minus the top row weighted 1 2 1.
- R11: During reset `out_valid` is low. After reset the operation code is 0 and the position is row 0, column 0, until the first frame start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 4 | Operation code, sampled at frame start |
| in_valid | input | 1 | Input pixel qualifier |
| in_sof | input | 1 | First pixel of a frame |
| in_eol | input | 1 | Last pixel of a line |
| in_rgb | input | 24 | Input pixel, R in 23:16, G in 15:8, B in 7:0 |
| out_valid | output | 1 | Output pixel qualifier |
| out_sof | output | 1 | Frame-start marker aligned to output |
| out_eol | output | 1 | Line-end marker aligned to output |
| out_rgb | output | 24 | Filtered pixel |

## Verification
The bench goes after the window corners: one-pixel-wide frames, single-line frames and the first two rows and columns. A block that replicated the wrong edge, or that read stale line-store data from an earlier frame, would give wrong values exactly there. All-black and all-white checkerboards drive the sharpen, relief and gradient sums past both ends of the 0..255 range. Without clamping, these pixels would wrap to small or large values. Idle gaps in the input would expose a window that shifts on empty cycles, or a valid signal that is not delayed. A code change in mid-frame would expose a mode that is taken from the port on every pixel instead of being held from the frame start.

// File: rtl/vf_pkg.sv
package vf_pkg;

    localparam int CH_W   = 8;
    localparam int N_CH   = 3;
    localparam int PIX_W  = CH_W * N_CH;

    localparam logic [3:0] MODE_GRAY    = 4'd1;
    localparam logic [3:0] MODE_BLUR    = 4'd3;
    localparam logic [3:0] MODE_EDGE    = 4'd5;
    localparam logic [3:0] MODE_EMBOSS  = 4'd6;
    localparam logic [3:0] MODE_SHARPEN = 4'd7;

    typedef logic [PIX_W-1:0] px_t;
    // column of three taps: [0] top, [1] middle, [2] bottom
    typedef px_t [2:0] col_t;
    // window of three columns: [0] left, [1] centre, [2] right
    typedef col_t [2:0] win_t;

    typedef struct packed {
        logic       valid;
        logic       sof;
        logic       eol;
        logic [3:0] mode;
        px_t        pix;
    } stage_t;

    function automatic logic [7:0] sat8(input logic signed [12:0] v);
        if (v < 0)        return 8'd0;
        if (v > 13'sd255) return 8'hFF;
        return v[7:0];
    endfunction

    function automatic logic signed [12:0] abs13(input logic signed [12:0] v);
        return (v < 0) ? -v : v;
    endfunction

    // n[r*3+c], r = row from top, c = column from left
    function automatic logic [7:0] apply_kernel(
        input logic [3:0]      mode,
        input logic [8:0][7:0] n,
        input logic [7:0]      self_c,
        input logic [7:0]      gray
    );
        logic signed [12:0] s [9];
        logic signed [12:0] acc;
        logic signed [12:0] gx;
        logic signed [12:0] gy;
        for (int i = 0; i < 9; i++) s[i] = $signed({5'b0, n[i]});
        case (mode)
            MODE_GRAY: return gray;
            MODE_BLUR: begin
                acc = s[0] + (s[1] <<< 1) + s[2]
                    + (s[3] <<< 1) + (s[4] <<< 2) + (s[5] <<< 1)
                    + s[6] + (s[7] <<< 1) + s[8];
                return sat8(acc >>> 4);
            end
            MODE_EDGE: begin
                gx  = (s[2] + (s[5] <<< 1) + s[8]) - (s[0] + (s[3] <<< 1) + s[6]);
                gy  = (s[6] + (s[7] <<< 1) + s[8]) - (s[0] + (s[1] <<< 1) + s[2]);
                acc = abs13(gx) + abs13(gy);
                return sat8(acc);
            end
            MODE_EMBOSS: begin
                acc = s[4] + s[5] + s[7] + (s[8] <<< 1) + 13'sd128
                    - (s[0] <<< 1) - s[1] - s[3];
                return sat8(acc);
            end
            MODE_SHARPEN: begin
                acc = (s[4] <<< 2) + s[4] - s[1] - s[3] - s[5] - s[7];
                return sat8(acc);
            end
            default: return self_c;
        endcase
    endfunction

endpackage

// File: rtl/vf_linebuf.sv
module vf_linebuf
    import vf_pkg::*;
#(
    parameter int MAX_W = 960,
    localparam int XW   = (MAX_W > 1) ? $clog2(MAX_W) : 1
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [XW-1:0] addr,
    input  px_t           pix,
    output px_t           up1,
    output px_t           up2
);
    px_t row1_mem [MAX_W];
    px_t row2_mem [MAX_W];

    // read-before-write: each column slot ages by one row per accepted pixel
    always_ff @(posedge clk) begin
        if (wr_en) begin
            up1            <= row1_mem[addr];
            up2            <= row2_mem[addr];
            row1_mem[addr] <= pix;
            row2_mem[addr] <= row1_mem[addr];
        end
    end
endmodule

// File: rtl/vf_window.sv
module vf_window
    import vf_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic row_first,
    input  logic row_second,
    input  logic col_first,
    input  logic col_second,
    input  px_t  bot,
    input  px_t  mid_raw,
    input  px_t  top_raw,
    output win_t win
);
    col_t col;

    // vertical replication of the first rows
    assign col[2] = bot;
    assign col[1] = row_first ? bot : mid_raw;
    assign col[0] = row_first ? bot : (row_second ? mid_raw : top_raw);

    // horizontal replication of the first columns
    always_ff @(posedge clk) begin
        if (rst) begin
            win <= '0;
        end else if (en) begin
            if (col_first) begin
                win <= {col, col, col};
            end else if (col_second) begin
                win[0] <= win[2];
                win[1] <= win[2];
                win[2] <= col;
            end else begin
                win[0] <= win[1];
                win[1] <= win[2];
                win[2] <= col;
            end
        end
    end
endmodule

// File: rtl/vf_kernel.sv
module vf_kernel
    import vf_pkg::*;
(
    input  logic [3:0] mode,
    input  win_t       win,
    input  px_t        pix,
    output px_t        res
);
    logic [15:0] luma_sum;
    logic [7:0]  luma;

    assign luma_sum = 16'(pix[23:16]) * 16'd77
                    + 16'(pix[15:8])  * 16'd150
                    + 16'(pix[7:0])   * 16'd29;
    assign luma = 8'(luma_sum >> 8);

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
        logic [8:0][7:0] taps;
        for (genvar r = 0; r < 3; r++) begin : g_row
            for (genvar c = 0; c < 3; c++) begin : g_col
                assign taps[r*3+c] = win[c][r][ch*CH_W +: CH_W];
            end
        end
        assign res[ch*CH_W +: CH_W] =
            apply_kernel(mode, taps, pix[ch*CH_W +: CH_W], luma);
    end
endmodule

// File: rtl/pix_filter3x3.sv
module pix_filter3x3
    import vf_pkg::*;
#(
    parameter int MAX_W = 960,
    localparam int XW   = (MAX_W > 1) ? $clog2(MAX_W) : 1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [3:0]  cfg_mode,
    input  logic        in_valid,
    input  logic        in_sof,
    input  logic        in_eol,
    input  logic [23:0] in_rgb,
    output logic        out_valid,
    output logic        out_sof,
    output logic        out_eol,
    output logic [23:0] out_rgb
);
    logic [XW-1:0] x_q;
    logic [1:0]    y_q;       // saturates at 2: only rows 0, 1 and later matter
    logic [3:0]    frame_mode;

    logic [XW-1:0] cur_x;
    logic [1:0]    cur_y;
    logic [3:0]    cur_mode;

    stage_t s1, s2;
    logic   s1_row_first, s1_row_second, s1_col_first, s1_col_second;
    px_t    up1, up2, k_res;
    win_t   win;

    assign cur_x    = in_sof ? '0 : x_q;
    assign cur_y    = in_sof ? 2'd0 : y_q;
    assign cur_mode = in_sof ? cfg_mode : frame_mode;

    always_ff @(posedge clk) begin
        if (rst) begin
            x_q           <= '0;
            y_q           <= '0;
            frame_mode    <= '0;
            s1            <= '0;
            s2            <= '0;
            s1_row_first  <= 1'b0;
            s1_row_second <= 1'b0;
            s1_col_first  <= 1'b0;
            s1_col_second <= 1'b0;
            out_valid     <= 1'b0;
            out_sof       <= 1'b0;
            out_eol       <= 1'b0;
            out_rgb       <= '0;
        end else begin
            s1.valid <= in_valid;
            s1.sof   <= in_valid & in_sof;
            s1.eol   <= in_valid & in_eol;
            s1.mode  <= cur_mode;
            s1.pix   <= in_rgb;
            if (in_valid) begin
                frame_mode    <= cur_mode;
                s1_row_first  <= (cur_y == 2'd0);
                s1_row_second <= (cur_y == 2'd1);
                s1_col_first  <= (cur_x == '0);
                s1_col_second <= (cur_x == XW'(1));
                if (in_eol) begin
                    x_q <= '0;
                    y_q <= (cur_y == 2'd2) ? 2'd2 : cur_y + 2'd1;
                end else begin
                    x_q <= cur_x + 1'b1;
                    y_q <= cur_y;
                end
            end
            s2        <= s1;
            out_valid <= s2.valid;
            out_sof   <= s2.sof;
            out_eol   <= s2.eol;
            out_rgb   <= k_res;
        end
    end

    vf_linebuf #(.MAX_W(MAX_W)) u_lines (
        .clk   (clk),
        .wr_en (in_valid),
        .addr  (cur_x),
        .pix   (in_rgb),
        .up1   (up1),
        .up2   (up2)
    );

    vf_window u_win (
        .clk        (clk),
        .rst        (rst),
        .en         (s1.valid),
        .row_first  (s1_row_first),
        .row_second (s1_row_second),
        .col_first  (s1_col_first),
        .col_second (s1_col_second),
        .bot        (s1.pix),
        .mid_raw    (up1),
        .top_raw    (up2),
        .win        (win)
    );

    vf_kernel u_kern (
        .mode (s2.mode),
        .win  (win),
        .pix  (s2.pix),
        .res  (k_res)
    );
endmodule

// File: rtl/vf_checker.sv
module vf_checker (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic       in_sof,
    input logic       in_eol,
    input logic       out_valid,
    input logic       out_sof,
    input logic       out_eol,
    input logic [3:0] frame_mode
);
    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst)                  since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    AST_VALID_DELAY: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3))); // R1

    AST_MARKER_DELAY: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd3 && out_valid) |->
            (out_sof == $past(in_sof, 3) && out_eol == $past(in_eol, 3))); // R2

    AST_MARKER_QUIET: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (!out_sof && !out_eol)); // R2

    AST_MODE_HELD: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && in_sof) |=> $stable(frame_mode)); // R3

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !out_valid); // R11
endmodule

bind pix_filter3x3 vf_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_sof     (in_sof),
    .in_eol     (in_eol),
    .out_valid  (out_valid),
    .out_sof    (out_sof),
    .out_eol    (out_eol),
    .frame_mode (frame_mode)
);

// File: tb/tb_pix_filter3x3.sv
module tb_pix_filter3x3;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  cfg_mode = 4'd0;
    logic        in_valid = 1'b0, in_sof = 1'b0, in_eol = 1'b0;
    logic [23:0] in_rgb = '0;
    logic        out_valid, out_sof, out_eol;
    logic [23:0] out_rgb;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pix_filter3x3 dut (
        .clk(clk), .rst(rst), .cfg_mode(cfg_mode),
        .in_valid(in_valid), .in_sof(in_sof), .in_eol(in_eol), .in_rgb(in_rgb),
        .out_valid(out_valid), .out_sof(out_sof), .out_eol(out_eol), .out_rgb(out_rgb)
    );

    // reference model state
    logic [23:0] img [0:15][0:15];
    int          model_mode = 0;
    bit          qv[$], qs[$], qe[$];
    logic [23:0] qp[$];
    string       qt[$];

    function automatic int tap(int y, int x, int r, int c, int ch);
        int yy = y - 2 + r;
        int xx = x - 2 + c;
        if (yy < 0) yy = 0;
        if (xx < 0) xx = 0;
        return int'(img[yy][xx][ch*8 +: 8]);
    endfunction

    function automatic int clampi(int v);
        return (v < 0) ? 0 : ((v > 255) ? 255 : v);
    endfunction

    function automatic int absi(int v);
        return (v < 0) ? -v : v;
    endfunction

    function automatic logic [23:0] model(int m, int x, int y);
        logic [23:0] res = img[y][x];
        int t[3][3];
        int v, gx, gy, lum;
        lum = (77 * int'(img[y][x][23:16]) + 150 * int'(img[y][x][15:8])
               + 29 * int'(img[y][x][7:0])) / 256;
        for (int ch = 0; ch < 3; ch++) begin
            for (int r = 0; r < 3; r++)
                for (int c = 0; c < 3; c++)
                    t[r][c] = tap(y, x, r, c, ch);
            case (m)
                1: v = lum;
                3: v = (t[0][0] + 2*t[0][1] + t[0][2] + 2*t[1][0] + 4*t[1][1]
                        + 2*t[1][2] + t[2][0] + 2*t[2][1] + t[2][2]) / 16;
                5: begin
                    gx = (t[0][2] + 2*t[1][2] + t[2][2]) - (t[0][0] + 2*t[1][0] + t[2][0]);
                    gy = (t[2][0] + 2*t[2][1] + t[2][2]) - (t[0][0] + 2*t[0][1] + t[0][2]);
                    v = clampi(absi(gx) + absi(gy));
                end
                6: v = clampi(-2*t[0][0] - t[0][1] - t[1][0] + t[1][1] + t[1][2]
                              + t[2][1] + 2*t[2][2] + 128);
                7: v = clampi(5*t[1][1] - t[0][1] - t[1][0] - t[1][2] - t[2][1]);
                default: v = int'(img[y][x][ch*8 +: 8]);
            endcase
            res[ch*8 +: 8] = v[7:0];
        end
        return res;
    endfunction

    task automatic push(bit v, bit s, bit e, logic [23:0] p, string tag);
        qv.push_back(v); qs.push_back(s); qe.push_back(e);
        qp.push_back(p); qt.push_back(tag);
    endtask

    task automatic check_out();
        bit ev, es, ee;
        logic [23:0] ep;
        string tg;
        if (qv.size() == 0) return;
        ev = qv.pop_front(); es = qs.pop_front(); ee = qe.pop_front();
        ep = qp.pop_front(); tg = qt.pop_front();
        n_chk++;
        if (out_valid !== ev) begin
            n_err++;
            $display("FAIL R1 out_valid actual=%0b expected=%0b", out_valid, ev);
        end
        if (ev && out_valid === 1'b1) begin
            n_chk++;
            if (out_sof !== es || out_eol !== ee) begin
                n_err++;
                $display("FAIL R2 markers actual=%0b%0b expected=%0b%0b",
                         out_sof, out_eol, es, ee);
            end
            n_chk++;
            if (out_rgb !== ep) begin
                n_err++;
                $display("FAIL %s pixel actual=%06h expected=%06h", tg, out_rgb, ep);
            end
        end else if (!ev && out_valid === 1'b0) begin
            n_chk++;
            if (out_sof !== 1'b0 || out_eol !== 1'b0) begin
                n_err++;
                $display("FAIL R2 idle markers actual=%0b%0b expected=00", out_sof, out_eol);
            end
        end
    endtask

    task automatic cyc(bit v, bit s, bit e, logic [23:0] p, int x, int y, string tag);
        @(negedge clk);
        check_out();
        in_valid = v; in_sof = v & s; in_eol = v & e; in_rgb = v ? p : 24'h0;
        if (v) begin
            img[y][x] = p;
            if (s) model_mode = int'(cfg_mode);
            push(1'b1, s, e, model(model_mode, x, y), tag);
        end else begin
            push(1'b0, 1'b0, 1'b0, 24'h0, "R1");
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 1'b0, 24'h0, 0, 0, "R1");
    endtask

    function automatic logic [23:0] gen(int pat, int x, int y);
        case (pat)
            1: return ((x + y) % 2 == 1) ? 24'hFFFFFF : 24'h000000;
            2: return {8'(x * 20), 8'(y * 30), 8'((x + y) * 10)};
            default: return 24'($urandom);
        endcase
    endfunction

    task automatic frame(int w, int h, int m, int pat, bit gaps, string tag, int mid);
        cfg_mode = 4'(m);
        for (int y = 0; y < h; y++) begin
            for (int x = 0; x < w; x++) begin
                if (gaps && ($urandom % 3 == 0)) idle(1 + $urandom % 2);
                if (mid >= 0 && y == 1 && x == 0) cfg_mode = 4'(mid);
                cyc(1'b1, (x == 0 && y == 0), (x == w - 1), gen(pat, x, y), x, y, tag);
            end
        end
        idle(2);
    endtask

    initial begin
        void'($urandom(32'h5eed));
        // R11: reset holds the output idle
        repeat (3) @(negedge clk);
        n_chk++;
        if (out_valid !== 1'b0) begin
            n_err++;
            $display("FAIL R11 out_valid in reset actual=%0b expected=0", out_valid);
        end
        rst = 1'b0;
        push(0, 0, 0, 0, "R1"); push(0, 0, 0, 0, "R1"); push(0, 0, 0, 0, "R1");
        // R11: before any frame start the block passes pixels through
        cfg_mode = 4'd3;
        for (int x = 0; x < 3; x++) cyc(1'b1, 1'b0, (x == 2), gen(0, x, 0), x, 0, "R11");
        idle(2);
        // R4: unlisted codes pass through
        frame(8, 5, 0,  0, 0, "R4", -1);
        frame(6, 4, 9,  0, 0, "R4", -1);
        frame(5, 3, 2,  2, 0, "R4", -1);
        frame(4, 3, 15, 0, 0, "R4", -1);
        // R5 grey
        frame(8, 5, 1, 0, 0, "R5", -1);
        frame(6, 4, 1, 1, 0, "R5", -1);
        // R7 blur
        frame(8, 6, 3, 0, 0, "R7", -1);
        frame(6, 4, 3, 1, 0, "R7", -1);
        // R10 edge
        frame(8, 5, 5, 0, 0, "R10", -1);
        frame(6, 5, 5, 1, 0, "R10", -1);
        frame(7, 4, 5, 2, 0, "R10", -1);
        // R9 emboss
        frame(8, 5, 6, 0, 0, "R9", -1);
        frame(6, 4, 6, 1, 0, "R9", -1);
        // R8 sharpen
        frame(8, 5, 7, 0, 0, "R8", -1);
        frame(6, 4, 7, 1, 0, "R8", -1);
        // R6 replication on tiny frames
        frame(1, 1, 3, 0, 0, "R6", -1);
        frame(2, 3, 5, 0, 0, "R6", -1);
        frame(3, 1, 7, 0, 0, "R6", -1);
        frame(1, 4, 6, 0, 0, "R6", -1);
        // R1 idle gaps inside the stream
        frame(7, 5, 3, 0, 1, "R1", -1);
        frame(7, 5, 5, 1, 1, "R1", -1);
        // R3 code change in mid-frame is ignored
        frame(6, 4, 7, 0, 0, "R3", 1);
        frame(6, 4, 0, 0, 1, "R3", 5);
        idle(4);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_err++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end
endmodule